// File: doc/BRIEF.md
# Sequential Address Bus Codec with Increment Line

This block squeezes switching activity out of an address bus whose traffic is mostly a linear walk through memory, such as instruction fetch. Next to the N address wires it drives a single extra wire, the increment flag. When the new address is exactly the previous logical address plus a fixed stride, the flag is raised and the address wires are not touched. While a linear run lasts, the only wire that can toggle is the flag itself, and only where the run starts or ends.

Both halves live in one top module so that either end of a link can instantiate it. The transmit half takes a strobed address and drives the coded bus. The receive half takes a coded bus and rebuilds the address. It keeps the last address it produced, steps that address by the stride when the flag is set, and otherwise loads the payload. The two halves share no state, so they can be wired back to back, or each can be connected to the matching half in another block. The stride and the address width are parameters. Arithmetic wraps modulo 2^N.

Top module: `t0_addr_codec`

## Requirements
- R1: While reset is held, and in the cycle after it, busAddr, busInc, busValid, outAddr and outValid are all 0.
- R2: The first accepted address after reset goes out with busInc = 0 and busAddr = that address, even when it equals 0 + STRIDE.
- R3: When an accepted address equals the last accepted address plus STRIDE, busInc becomes 1 and busAddr keeps its previous value.
- R4: Any other accepted address goes out with busInc = 0 and busAddr equal to the address.
- R5: The sequential test wraps modulo 2^ADDR_W. An address of 0 following 2^ADDR_W - STRIDE is coded with busInc = 1.
- R6: A cycle with inValid = 0 leaves busAddr and busInc unchanged and gives busValid = 0 on the following cycle.
- R7: When rxValid = 1 and rxInc = 1, outAddr becomes the previous outAddr plus STRIDE (mod 2^ADDR_W), and rxAddr is ignored.
- R8: When rxValid = 1 and rxInc = 0, outAddr becomes rxAddr.
- R9: A cycle with rxValid = 0 leaves outAddr unchanged and gives outValid = 0 on the following cycle, whatever rxInc and rxAddr hold.
- R10: During an increment run the sequential test uses the last logical address, not the frozen busAddr. A run can therefore go on for any number of steps.
- R11: busValid follows inValid, and outValid follows rxValid, one clock later. When the bus is looped back into the receiver, outAddr reproduces each sent address two clocks after it was strobed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Transmit strobe for inAddr |
| inAddr | input | ADDR_W | Logical address to transmit |
| busValid | output | 1 | Coded bus carries a transfer |
| busInc | output | 1 | Increment flag on the coded bus |
| busAddr | output | ADDR_W | Address wires of the coded bus |
| rxValid | input | 1 | Receive strobe |
| rxInc | input | 1 | Received increment flag |
| rxAddr | input | ADDR_W | Received address wires |
| outValid | output | 1 | Rebuilt address is fresh |
| outAddr | output | ADDR_W | Rebuilt logical address |

## Verification
With the bus looped back, the transmitter can end a run in the same clock in which the receiver is still expanding the last increment word of that run. The two halves then take opposite branches in one cycle: the transmitter loads a new address while the receiver adds the stride. The bench sends linear runs that break into jumps, and wrapped runs that break into jumps. Each cycle it compares the rebuilt address with the address strobed in two clocks earlier, and it checks that the address wires stayed still for the whole run.

// File: rtl/t0_codec_pkg.sv
package t0_codec_pkg;

  // Strobes passed from the control unit to the datapath each cycle
  typedef struct packed {
    logic encCapture;  // accept inAddr this cycle
    logic encUseInc;   // send it as an increment word
    logic decCapture;  // accept the received word
    logic decUseAdd;   // rebuild by adding the stride
  } ctrlStrobes_t;

endpackage

// File: rtl/t0_codec_ctrl.sv
module t0_codec_ctrl
  import t0_codec_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         seqHit,
  input  logic         rxValid,
  input  logic         rxInc,
  output ctrlStrobes_t strobes
);

  // Set once a reference address has been shared with the receiver
  logic haveRef;

  always_ff @(posedge clk) begin
    if (rst) begin
      haveRef <= 1'b0;
    end else if (inValid) begin
      haveRef <= 1'b1;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.encCapture = inValid;
    strobes.encUseInc  = inValid && haveRef && seqHit;
    strobes.decCapture = rxValid;
    strobes.decUseAdd  = rxValid && rxInc;
  end

endmodule

// File: rtl/t0_codec_datapath.sv
module t0_codec_datapath
  import t0_codec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              seqHit,
  output logic              busValid,
  output logic              busInc,
  output logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] rxAddr,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  // Last logical address accepted; differs from busAddr during runs
  logic [ADDR_W-1:0] lastAddr;
  logic [ADDR_W-1:0] nextSeq;
  logic [ADDR_W-1:0] recNext;

  assign nextSeq = lastAddr + STEP;
  assign seqHit  = (inAddr == nextSeq);
  assign recNext = outAddr + STEP;

  // Transmit side
  always_ff @(posedge clk) begin
    if (rst) begin
      lastAddr <= '0;
      busAddr  <= '0;
      busInc   <= 1'b0;
      busValid <= 1'b0;
    end else begin
      busValid <= strobes.encCapture;
      if (strobes.encCapture) begin
        lastAddr <= inAddr;
        busInc   <= strobes.encUseInc;
        if (!strobes.encUseInc) begin
          busAddr <= inAddr;
        end
      end
    end
  end

  // Receive side
  always_ff @(posedge clk) begin
    if (rst) begin
      outAddr  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.decCapture;
      if (strobes.decCapture) begin
        outAddr <= strobes.decUseAdd ? recNext : rxAddr;
      end
    end
  end

endmodule

// File: rtl/t0_addr_codec.sv
module t0_addr_codec
  import t0_codec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              busValid,
  output logic              busInc,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              rxValid,
  input  logic              rxInc,
  input  logic [ADDR_W-1:0] rxAddr,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr
);

  ctrlStrobes_t strobes;
  logic         seqHit;

  t0_codec_ctrl ctrlUnit (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .seqHit  (seqHit),
    .rxValid (rxValid),
    .rxInc   (rxInc),
    .strobes (strobes)
  );

  t0_codec_datapath #(
    .ADDR_W (ADDR_W),
    .STRIDE (STRIDE)
  ) dataUnit (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inAddr   (inAddr),
    .seqHit   (seqHit),
    .busValid (busValid),
    .busInc   (busInc),
    .busAddr  (busAddr),
    .rxAddr   (rxAddr),
    .outValid (outValid),
    .outAddr  (outAddr)
  );

endmodule

// File: rtl/t0_addr_codec_chk.sv
module t0_addr_codec_chk #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              busValid,
  input logic              busInc,
  input logic [ADDR_W-1:0] busAddr,
  input logic              rxValid,
  input logic              rxInc,
  input logic [ADDR_W-1:0] rxAddr,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  logic seenValid;
  always_ff @(posedge clk) begin
    if (rst) seenValid <= 1'b0;
    else if (inValid) seenValid <= 1'b1;
  end

  AST_FIRST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (inValid && !seenValid) |=> !busInc); // R2

  AST_INC_FREEZES_BUS: assert property (@(posedge clk) disable iff (rst)
    (busValid && busInc) |-> $stable(busAddr)); // R3

  AST_IDLE_HOLDS_BUS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(busAddr) && $stable(busInc) && !busValid)); // R6

  AST_DEC_ADD: assert property (@(posedge clk) disable iff (rst)
    (rxValid && rxInc) |=> (outAddr == $past(outAddr) + STEP)); // R7

  AST_DEC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (rxValid && !rxInc) |=> (outAddr == $past(rxAddr))); // R8

  AST_DEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rxValid |=> ($stable(outAddr) && !outValid)); // R9

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    inValid |=> busValid); // R11

endmodule

bind t0_addr_codec t0_addr_codec_chk #(
  .ADDR_W (ADDR_W),
  .STRIDE (STRIDE)
) chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .busValid (busValid),
  .busInc   (busInc),
  .busAddr  (busAddr),
  .rxValid  (rxValid),
  .rxInc    (rxInc),
  .rxAddr   (rxAddr),
  .outValid (outValid),
  .outAddr  (outAddr)
);

// File: tb/t0_addr_codec_test.sv
module t0_addr_codec_test;

  localparam int AW     = 32;
  localparam int ST     = 4;
  localparam int CLK_NS = 10;
  localparam logic [AW-1:0] TOP = {AW{1'b1}} - AW'(ST) + AW'(1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [AW-1:0] inAddr = '0;
  logic          busValid, busInc;
  logic [AW-1:0] busAddr;
  logic          loop = 1'b0;
  logic          tbRxValid = 1'b0, tbRxInc = 1'b0;
  logic [AW-1:0] tbRxAddr = '0;
  logic          rxValid, rxInc;
  logic [AW-1:0] rxAddr;
  logic          outValid;
  logic [AW-1:0] outAddr;

  int nTests = 0;
  int nFail  = 0;

  assign rxValid = loop ? busValid : tbRxValid;
  assign rxInc   = loop ? busInc   : tbRxInc;
  assign rxAddr  = loop ? busAddr  : tbRxAddr;

  always #(CLK_NS/2) clk = ~clk;

  t0_addr_codec #(.ADDR_W(AW), .STRIDE(ST)) uut (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inAddr(inAddr),
    .busValid(busValid), .busInc(busInc), .busAddr(busAddr),
    .rxValid(rxValid), .rxInc(rxInc), .rxAddr(rxAddr),
    .outValid(outValid), .outAddr(outAddr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive transmit inputs at a falling edge, return at the next one
  task automatic txStep(input logic v, input logic [AW-1:0] a);
    inValid = v; inAddr = a;
    @(negedge clk);
  endtask

  task automatic rxStep(input logic v, input logic inc, input logic [AW-1:0] a);
    tbRxValid = v; tbRxInc = inc; tbRxAddr = a;
    @(negedge clk);
  endtask

  task automatic expBus(input string tag, input logic v, input logic inc, input logic [AW-1:0] a);
    check(busValid == v, {tag, " busValid"}, 64'(busValid), 64'(v));
    check(busInc == inc, {tag, " busInc"}, 64'(busInc), 64'(inc));
    check(busAddr == a, {tag, " busAddr"}, 64'(busAddr), 64'(a));
  endtask

  task automatic testReset();
    check(busAddr == 0 && busInc == 0 && busValid == 0, "R1 bus", {busValid, busInc, 32'(busAddr)}, 0);
    check(outAddr == 0 && outValid == 0, "R1 out", {outValid, 32'(outAddr)}, 0);
  endtask

  task automatic testEncoder();
    txStep(1, AW'(ST));  expBus("R2 first", 1, 0, AW'(ST));
    txStep(1, 8);        expBus("R3 seq", 1, 1, AW'(ST));
    txStep(1, 100);      expBus("R4 jump", 1, 0, 100);
    txStep(1, 104);      expBus("R3 seq2", 1, 1, 100);
    txStep(0, 555);      expBus("R6 idle", 0, 1, 100);
    txStep(1, 108);      expBus("R10 run", 1, 1, 100);
    txStep(1, 112);      expBus("R10 run2", 1, 1, 100);
    txStep(1, 120);      expBus("R4 skip", 1, 0, 120);
    txStep(1, 116);      expBus("R4 back", 1, 0, 116);
    txStep(0, 120);      expBus("R6 idle2", 0, 0, 116);
    txStep(1, TOP);      expBus("R4 top", 1, 0, TOP);
    txStep(1, 0);        expBus("R5 wrap", 1, 1, TOP);
    txStep(1, AW'(ST));  expBus("R5 after", 1, 1, TOP);
    txStep(0, 0);
  endtask

  task automatic testDecoder();
    rxStep(1, 0, 1000);
    check(outAddr == 1000 && outValid, "R8 load", 64'(outAddr), 1000);
    rxStep(1, 1, 0);
    check(outAddr == 1004, "R7 add", 64'(outAddr), 1004);
    rxStep(1, 1, 77);
    check(outAddr == 1008, "R7 ignores payload", 64'(outAddr), 1008);
    rxStep(0, 1, 5);
    check(outAddr == 1008 && !outValid, "R9 idle", {outValid, 32'(outAddr)}, 1008);
    rxStep(1, 0, TOP);
    check(outAddr == TOP, "R8 top", 64'(outAddr), 64'(TOP));
    rxStep(1, 1, 9);
    check(outAddr == 0, "R7 wrap", 64'(outAddr), 0);
    rxStep(0, 0, 0);
    check(!outValid, "R9 valid low", 64'(outValid), 0);
  endtask

  // loopback: run breaks while the receiver expands an increment word
  task automatic testLoopback();
    logic [AW-1:0] seq [12];
    logic [AW-1:0] prev;
    logic [AW-1:0] runBus;
    seq = '{200, 204, 208, 212, 300, 304, 308, TOP, 0, 4, 64, 68};
    loop = 1'b1;
    prev = '0;
    runBus = '0;
    for (int i = 0; i < 12; i++) begin
      txStep(1, seq[i]);
      if (i > 0) begin
        check(outValid, "R11 loop valid", 64'(outValid), 1);
        check(outAddr == prev, "R11 loop addr", 64'(outAddr), 64'(prev));
      end
      if (i > 0 && seq[i] == prev + AW'(ST))
        check(busAddr == runBus, "R3 frozen in run", 64'(busAddr), 64'(runBus));
      else
        runBus = seq[i];
      prev = seq[i];
    end
    txStep(0, 0);
    check(outAddr == prev && outValid, "R11 loop tail", 64'(outAddr), 64'(prev));
    loop = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    nFail++;
    nTests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testEncoder();
    testDecoder();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    testLoopback();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule